// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting channel of a PC-style interval timer. It runs from a fixed input clock, which is delivered as a one-cycle count enable on the system clock; the nominal input rate is 1193182 Hz. A host programs it over a byte-wide bus. A control address takes command bytes and a data address takes count bytes and returns count bytes. A reload value for a wanted rate is normally the input frequency divided by that rate, rounded to the nearest integer.

The channel has two operating modes. Rate-generator mode gives one interrupt pulse per reload period and serves as a periodic tick. Square-wave mode drives a waveform that is used as a tone. That tone reaches the speaker pin only when both bits of a separate enable input are set. A latch command freezes a snapshot of the count, so that a low-then-high byte readback is coherent while the counter keeps running. A new count takes effect only once both of its bytes have arrived.

Top module: `interval_channel`

## Requirements
- R1: After reset, `waveOut` is 1, `tickPulse` is 0, and the live count reads as 0x00 followed by 0x00.
- R2: A byte written with `busAddr`=1 is a command only when bits [7:6] equal `CHAN_ID`. Bits [5:4]=11 with mode bits [3:1]=010 (rate) or 011 (square) and bit 0 = 0 form a mode command. Bits [5:4]=00 form a latch command. Any other command byte is ignored and leaves every state untouched.
- R3: A mode command returns the read and write byte order to the low byte, drops any held latch, stops counting and sets `waveOut` to 1.
- R4: A count is written as the low byte and then the high byte at `busAddr`=0. The low byte alone changes nothing. After the high byte, the counter loads the value on the next cycle in which `countEn`=1.
- R5: In rate mode the count drops by one per enabled tick. When it is 1, it reloads and `tickPulse` is high for one cycle, so the pulses come every N enabled ticks.
- R6: A reload value of 0 means 65536. After the load tick and one more tick, the count reads 0xFFFF in rate mode and 0xFFFE in square mode.
- R7: In square mode the count drops by two per tick, using the reload value with bit 0 cleared. `waveOut` is high for N/2 ticks and then low for N/2 ticks when N is even.
- R8: A latch command captures the count. The next two data reads return the captured low byte and then the captured high byte, even while the counter keeps running.
- R9: A latch command issued while a captured value has not been fully read is ignored.
- R10: `toneOut` equals `waveOut` when `spkEnable`=11 and is 0 otherwise.
- R11: With no latch held, data reads alternate between the low byte and the high byte of the live count.
- R12: While `countEn`=0, the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Bus write strobe |
| busRdEn | input | 1 | Bus read strobe (data address only has an effect) |
| busAddr | input | 1 | 0 = count data, 1 = command |
| busWrData | input | 8 | Write byte |
| busRdData | output | 8 | Read byte (live or latched count) |
| countEn | input | 1 | One pulse per input-clock period |
| spkEnable | input | 2 | Separate speaker enable bits |
| tickPulse | output | 1 | Rate-mode terminal-count pulse |
| waveOut | output | 1 | Square-wave output |
| toneOut | output | 1 | Gated tone output |

## Verification
Bus writes and commands act on the clock edge of their cycle. The read data depends combinationally on the byte-order state, so the bench drives each access at a falling edge and samples the read byte a nanosecond later. A committed count appears one enabled tick after the high byte. Pulses and waveform levels change on the edge of the tick that causes them, so the bench counts sampled falling edges between events and compares these counts with the N or N/2 that its helper functions give. Checks on frozen and latched values use exact tick counts, with `countEn` held low between them.

// File: rtl/interval_pkg.sv
package interval_pkg;

  typedef enum logic [2:0] {
    OPM_RATE   = 3'b010,
    OPM_SQUARE = 3'b011
  } opMode_t;

  localparam logic [1:0] ACC_LATCH = 2'b00;
  localparam logic [1:0] ACC_LOHI  = 2'b11;

  typedef struct packed {
    logic    modeWr;
    opMode_t mode;
    logic    loadLo;
    logic    loadHi;
    logic    latchCapture;
    logic    rdHigh;
    logic    useLatch;
  } ctrlStrobe_t;

  function automatic int reloadForRate(int inFreq, int rate);
    return (inFreq + rate / 2) / rate;
  endfunction

endpackage

// File: rtl/interval_ctrl.sv
module interval_ctrl
  import interval_pkg::*;
#(
  parameter logic [1:0] CHAN_ID = 2'd0,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              busAddr,
  input  logic [BYTE_W-1:0] busWrData,
  output ctrlStrobe_t       strb
);

  logic    wrHigh, rdHigh, latchHeld;
  opMode_t curMode;
  logic    chanHit, modeOk, modeWrCmd, latchCmd, dataWr, dataRd;
  logic [2:0] modeCode;

  always_comb begin
    modeCode  = busWrData[3:1];
    chanHit   = busWrData[7:6] == CHAN_ID;
    modeOk    = (modeCode == OPM_RATE || modeCode == OPM_SQUARE) && !busWrData[0];
    modeWrCmd = busWrEn && busAddr && chanHit && busWrData[5:4] == ACC_LOHI && modeOk;
    latchCmd  = busWrEn && busAddr && chanHit && busWrData[5:4] == ACC_LATCH;
    dataWr    = busWrEn && !busAddr;
    dataRd    = busRdEn && !busAddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrHigh    <= 1'b0;
      rdHigh    <= 1'b0;
      latchHeld <= 1'b0;
      curMode   <= OPM_RATE;
    end else if (modeWrCmd) begin
      curMode   <= opMode_t'(modeCode);
      wrHigh    <= 1'b0;
      rdHigh    <= 1'b0;
      latchHeld <= 1'b0;
    end else begin
      if (latchCmd && !latchHeld) begin
        latchHeld <= 1'b1;
        rdHigh    <= 1'b0;
      end else if (dataRd) begin
        rdHigh <= !rdHigh;
        if (rdHigh && latchHeld) latchHeld <= 1'b0;
      end
      if (dataWr) wrHigh <= !wrHigh;
    end
  end

  always_comb begin
    strb.modeWr       = modeWrCmd;
    strb.mode         = curMode;
    strb.loadLo       = dataWr && !wrHigh;
    strb.loadHi       = dataWr && wrHigh;
    strb.latchCapture = latchCmd && !latchHeld;
    strb.rdHigh       = rdHigh;
    strb.useLatch     = latchHeld;
  end

  // R3: a mode command leaves both byte orders at the low byte
  p_flop_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    modeWrCmd |=> (!rdHigh && !wrHigh && !latchHeld));

endmodule

// File: rtl/interval_datapath.sv
module interval_datapath
  import interval_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strb,
  input  logic [BYTE_W-1:0] wrByte,
  input  logic              countEn,
  output logic [BYTE_W-1:0] rdByte,
  output logic              waveOut,
  output logic              tickPulse
);

  localparam int CNT_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] loHold;
  logic [CNT_W-1:0]  reloadVal, cnt, latchVal, evenReload, startVal, srcVal;
  logic              loadPending, running, waveReg, tickReg;

  always_comb begin
    evenReload = {reloadVal[CNT_W-1:1], 1'b0};
    startVal   = (strb.mode == OPM_SQUARE) ? evenReload : reloadVal;
    srcVal     = strb.useLatch ? latchVal : cnt;
    rdByte     = strb.rdHigh ? srcVal[CNT_W-1:BYTE_W] : srcVal[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loHold      <= '0;
      reloadVal   <= '0;
      cnt         <= '0;
      loadPending <= 1'b0;
      running     <= 1'b0;
      waveReg     <= 1'b1;
      tickReg     <= 1'b0;
    end else if (strb.modeWr) begin
      running     <= 1'b0;
      loadPending <= 1'b0;
      waveReg     <= 1'b1;
      tickReg     <= 1'b0;
    end else begin
      tickReg <= 1'b0;
      if (countEn) begin
        if (loadPending) begin
          cnt         <= startVal;
          running     <= 1'b1;
          waveReg     <= 1'b1;
          loadPending <= 1'b0;
        end else if (running) begin
          if (strb.mode == OPM_RATE) begin
            if (cnt == CNT_W'(1)) begin
              cnt     <= reloadVal;
              tickReg <= 1'b1;
            end else begin
              cnt <= cnt - CNT_W'(1);
            end
          end else begin
            if (cnt == CNT_W'(2)) begin
              cnt     <= evenReload;
              waveReg <= !waveReg;
            end else begin
              cnt <= cnt - CNT_W'(2);
            end
          end
        end
      end
      if (strb.loadLo) loHold <= wrByte;
      if (strb.loadHi) begin
        reloadVal   <= {wrByte, loHold};
        loadPending <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latchVal <= '0;
    else if (strb.latchCapture) latchVal <= cnt;
  end

  assign waveOut   = waveReg;
  assign tickPulse = tickReg;

  // R12: the count holds while the input clock enable is low
  p_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !countEn |=> $stable(cnt));

  // R9: a held snapshot does not move until it is released
  p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.useLatch && !strb.modeWr) |=> $stable(latchVal));

  // R5: terminal-count pulses come only from rate mode
  p_pulse_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tickPulse |-> $past(strb.mode) == OPM_RATE);

  // R7: in square mode a running count is always even
  p_square_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && strb.mode == OPM_SQUARE && !$past(strb.modeWr)) |-> !cnt[0]);

endmodule

// File: rtl/interval_channel.sv
module interval_channel
  import interval_pkg::*;
#(
  parameter logic [1:0] CHAN_ID = 2'd0,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              busAddr,
  input  logic [BYTE_W-1:0] busWrData,
  output logic [BYTE_W-1:0] busRdData,
  input  logic              countEn,
  input  logic [1:0]        spkEnable,
  output logic              tickPulse,
  output logic              waveOut,
  output logic              toneOut
);

  ctrlStrobe_t strb;

  interval_ctrl #(.CHAN_ID(CHAN_ID), .BYTE_W(BYTE_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .strb(strb)
  );

  interval_datapath #(.BYTE_W(BYTE_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrByte(busWrData),
    .countEn(countEn), .rdByte(busRdData), .waveOut(waveOut),
    .tickPulse(tickPulse)
  );

  assign toneOut = waveOut & (&spkEnable);

  // R10: no tone leaves the block unless both enable bits are set
  p_tone_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (spkEnable != 2'b11) |-> !toneOut);

endmodule

// File: tb/interval_channel_tb.sv
`timescale 1ns/1ps
module interval_channel_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0, busAddr = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic countEn = 1'b0;
  logic [1:0] spkEnable = 2'b00;
  logic tickPulse, waveOut, toneOut;

  int checks = 0;
  int fails = 0;

  localparam logic [7:0] CW_RATE  = 8'h34;
  localparam logic [7:0] CW_SQ    = 8'h36;
  localparam logic [7:0] CW_LATCH = 8'h00;
  localparam logic [7:0] CW_OTHER = 8'h74;
  localparam logic [7:0] CW_BADMD = 8'h30;

  always #2 clk = ~clk;

  interval_channel dut_i (
    .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .countEn(countEn), .spkEnable(spkEnable), .tickPulse(tickPulse),
    .waveOut(waveOut), .toneOut(toneOut)
  );

  function automatic int expRatePeriod(int n);
    return (n == 0) ? 65536 : n;
  endfunction

  function automatic int expSquareHalf(int n);
    return (n < 2) ? 32768 : n / 2;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic busWrite(logic addr, logic [7:0] data);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = addr; busWrData = data;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = 1'b0;
  endtask

  task automatic busRead(output logic [7:0] data);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = 1'b0;
    #1 data = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic readWord(output int val);
    logic [7:0] lo, hi;
    busRead(lo);
    busRead(hi);
    val = {hi, lo};
  endtask

  task automatic loadCount(int n);
    busWrite(1'b0, n[7:0]);
    busWrite(1'b0, n[15:8]);
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    countEn = 1'b1;
    repeat (n) @(negedge clk);
    countEn = 1'b0;
  endtask

  task automatic ratePeriod(output int c);
    do @(negedge clk); while (!tickPulse);
    c = 0;
    do begin @(negedge clk); c++; end while (!tickPulse);
  endtask

  task automatic squareHalves(output int lo, output int hi);
    do @(negedge clk); while (waveOut);
    lo = 0;
    while (!waveOut) begin lo++; @(negedge clk); end
    hi = 0;
    while (waveOut) begin hi++; @(negedge clk); end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v, p, lo, hi;
    logic [7:0] b;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 wave", waveOut, 1);
    chk("R1 tick", tickPulse, 0);
    readWord(v);
    chk("R1 count", v, 0);

    // R4/R11 load 1000, freeze, read live
    busWrite(1'b1, CW_RATE);
    loadCount(1000);
    ticks(1);
    readWord(v);
    chk("R4 load", v, 1000);
    ticks(5);
    // R8 latch then keep counting
    busWrite(1'b1, CW_LATCH);
    ticks(3);
    readWord(v);
    chk("R8 latched", v, 995);
    readWord(v);
    chk("R11 live", v, 992);
    // R9 second latch ignored while held
    busWrite(1'b1, CW_LATCH);
    ticks(3);
    busWrite(1'b1, CW_LATCH);
    ticks(2);
    readWord(v);
    chk("R9 first snapshot", v, 992);
    readWord(v);
    chk("R12 live after release", v, 987);

    // R3 mode command resets byte order and stops counting
    busRead(b);
    chk("R11 low byte", b, 8'hDB);
    busWrite(1'b1, CW_RATE);
    busRead(b);
    chk("R3 order reset", b, 8'hDB);
    busRead(b);
    chk("R11 high byte", b, 8'h03);
    ticks(4);
    readWord(v);
    chk("R3 stopped", v, 987);

    // R2 foreign channel and invalid mode ignored
    busRead(b);
    busWrite(1'b1, CW_OTHER);
    busRead(b);
    chk("R2 other channel", b, 8'h03);
    busRead(b);
    busWrite(1'b1, CW_BADMD);
    busRead(b);
    chk("R2 invalid mode", b, 8'h03);

    // R4 low byte alone has no effect
    busWrite(1'b0, 8'h10);
    ticks(3);
    readWord(v);
    chk("R4 low only", v, 987);
    busWrite(1'b0, 8'h00);
    ticks(1);
    readWord(v);
    chk("R4 both halves", v, 16);

    // R6 zero reload
    busWrite(1'b1, CW_RATE);
    loadCount(0);
    ticks(2);
    readWord(v);
    chk("R6 rate zero", v, 16'hFFFF);
    busWrite(1'b1, CW_SQ);
    loadCount(0);
    ticks(2);
    readWord(v);
    chk("R6 square zero", v, 16'hFFFE);

    // R5 rate period
    busWrite(1'b1, CW_RATE);
    loadCount(5);
    @(negedge clk) countEn = 1'b1;
    ratePeriod(p);
    chk("R5 period", p, expRatePeriod(5));
    countEn = 1'b0;

    // R7 square halves, R10 gating
    busWrite(1'b1, CW_SQ);
    loadCount(10);
    @(negedge clk) countEn = 1'b1;
    squareHalves(lo, hi);
    chk("R7 low half", lo, expSquareHalf(10));
    chk("R7 high half", hi, expSquareHalf(10));
    spkEnable = 2'b01;
    v = 0;
    repeat (20) begin @(negedge clk); if (toneOut) v++; end
    chk("R10 gated off", v, 0);
    spkEnable = 2'b11;
    v = 0;
    repeat (20) begin @(negedge clk); if (toneOut != waveOut) v++; end
    chk("R10 passes wave", v, 0);
    countEn = 1'b0;
    spkEnable = 2'b00;

    // constrained random reloads in both modes
    for (int i = 0; i < 8; i++) begin
      bit sq;
      int n;
      sq = 1'($urandom % 2);
      n = 4 + 2 * int'($urandom % 18);
      @(negedge clk) countEn = 1'b0;
      busWrite(1'b1, sq ? CW_SQ : CW_RATE);
      loadCount(n);
      @(negedge clk) countEn = 1'b1;
      if (sq) begin
        squareHalves(lo, hi);
        chk("R7 random low", lo, expSquareHalf(n));
        chk("R7 random high", hi, expSquareHalf(n));
      end else begin
        ratePeriod(p);
        chk("R5 random period", p, expRatePeriod(n));
      end
    end
    countEn = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule